// File: doc/BRIEF.md
# Tagged Fully Associative Translation Cache

This block holds a small set of virtual-page to physical-frame translations. Any translation can sit in any slot. Each slot is qualified by an address-space identifier, so translations that belong to different processes can be resident together. A lookup presents a virtual page number, an identifier, the page offset and the access kind (read or write). All valid slots are compared in parallel. The registered result returns one of three outcomes: a hit with the physical address, a protection fault when the matching slot forbids that access, or a miss.

Translations are installed through a separate fill port, typically driven by a page walker. Slot choice is made by the block. A resident copy of the same page and identifier is overwritten in place. Failing that, the lowest-numbered empty slot is used. When every slot is occupied, a slot is picked by a free-running LFSR. Two control inputs discard translations: one clears every slot at once, the other clears only the slots of one identifier.

The lookup side is a valid/ready stream with a one-deep registered result stage. A lookup is accepted on a cycle where `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever no result is pending or the pending result is being taken that cycle. A result is held, unchanged, until `res_ready` is seen high. The fill side is also valid/ready: `fill_ready` drops only in a cycle where a flush is requested.

Top module: `vpn_tlb`

## Requirements
- R1: A lookup accepted on edge k yields `res_valid`=1 after edge k. On a hit, `res_hit`=1 and `res_paddr` = {stored frame number, `lk_off`}. The low OFF_W bits are exactly the offset presented, unchanged.
- R2: When no valid slot holds both the same page number and the same identifier, the result has `res_hit`=0 and `res_fault`=0.
- R3: Two translations with the same page number and different identifiers are both resident. Each lookup returns the frame of its own identifier.
- R4: On a match, a read (`lk_write`=0) with a stored read permission of 0 gives `res_fault`=1 and `res_hit`=0. A write (`lk_write`=1) with a stored write permission of 0 gives the same outcome. `res_hit` and `res_fault` are never both 1.
- R5: Fills into a table that has empty slots never displace a valid translation, so 16 distinct fills after a flush are all resident.
- R6: A fill of a new translation into a full table displaces exactly one resident translation. The new one is then resident.
- R7: A fill whose page number and identifier match a resident slot rewrites that slot. The new frame and permissions are returned, and no other translation is lost.
- R8: `flush_all`=1 invalidates every slot in that cycle. A lookup accepted on the following edge misses. While any flush input is high, `fill_ready`=0 and a fill is not taken.
- R9: `flush_asid_en`=1 invalidates only the slots whose identifier equals `flush_asid`. Translations of other identifiers still hit.
- R10: `lk_ready` = !`res_valid` || `res_ready`. While `res_valid`=1 and `res_ready`=0, the result outputs stay stable. A held lookup is accepted on the cycle the pending result is taken.
- R11: After reset `res_valid`=0, `lk_ready`=1, `fill_ready`=1, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_vpn | input | VPN_W (20) | Virtual page number to translate |
| lk_asid | input | ASID_W (8) | Address-space identifier of the lookup |
| lk_off | input | OFF_W (12) | Page offset, passed to the result |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | Translation found and access allowed |
| res_fault | output | 1 | Translation found but access forbidden |
| res_paddr | output | PFN_W+OFF_W (32) | Physical address {frame, offset} |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted (low during flush) |
| fill_vpn | input | VPN_W (20) | Page number of the new translation |
| fill_asid | input | ASID_W (8) | Identifier of the new translation |
| fill_pfn | input | PFN_W (20) | Physical frame number |
| fill_rd_ok | input | 1 | Read permitted |
| fill_wr_ok | input | 1 | Write permitted |
| flush_all | input | 1 | Invalidate all slots |
| flush_asid_en | input | 1 | Invalidate slots of one identifier |
| flush_asid | input | ASID_W (8) | Identifier to invalidate |

## Verification
The bench targets identifier aliasing. A compare that ignores the identifier returns the wrong frame for one of two same-page translations, or drops one of them. On a full table it checks that exactly fifteen of the sixteen earlier translations survive a new fill. A victim picker that ignores empty slots, or that evicts several, breaks that count, and a refill that creates a duplicate instead of rewriting breaks the later lookups of its neighbours. Read and write permissions are tested separately, so swapped permission bits show up as wrong faults. The bench also tests a selective flush that clears too much, a flush that lets a concurrent fill through, and a result register that changes or is lost under back-pressure.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } tlb_perm_t;

  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_PFN_W   = 20;
  localparam int unsigned DEF_OFF_W   = 12;

  function automatic logic access_ok(input tlb_perm_t p, input logic is_write);
    return is_write ? p.wr : p.rd;
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
`timescale 1ns/1ps
module tlb_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 20,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              q_any,
  output logic [PFN_W-1:0]  q_pfn,
  output tlb_perm_t         q_perm,
  input  logic [VPN_W-1:0]  f_vpn,
  input  logic [ASID_W-1:0] f_asid,
  output logic [N-1:0]      f_match,
  output logic [N-1:0]      valid_vec,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  tlb_perm_t         wr_perm,
  input  logic              clr_all,
  input  logic              clr_asid_en,
  input  logic [ASID_W-1:0] clr_asid
);
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  tlb_perm_t         perm_q [N];
  logic [N-1:0]      q_match;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign q_match[i] = valid_vec[i] && (vpn_q[i] == q_vpn) && (asid_q[i] == q_asid);
    assign f_match[i] = valid_vec[i] && (vpn_q[i] == f_vpn) && (asid_q[i] == f_asid);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
      end else if (clr_all) begin
        valid_vec[i] <= 1'b0;
      end else if (clr_asid_en && (asid_q[i] == clr_asid)) begin
        valid_vec[i] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        valid_vec[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        vpn_q[i]  <= f_vpn;
        asid_q[i] <= f_asid;
        pfn_q[i]  <= wr_pfn;
        perm_q[i] <= wr_perm;
      end
    end
  end

  always_comb begin
    q_pfn  = '0;
    q_perm = '0;
    for (int i = 0; i < N; i++) begin
      q_pfn  = q_pfn  | (pfn_q[i] & {PFN_W{q_match[i]}});
      q_perm = q_perm | (perm_q[i] & {2{q_match[i]}});
    end
  end

  assign q_any = |q_match;
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int unsigned N      = 16,
  parameter int unsigned RAND_W = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      valid_vec,
  input  logic [N-1:0]      same_vec,
  input  logic [RAND_W-1:0] rnd,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0]  same_idx, free_idx;
  logic              same_hit, free_hit;
  logic [RAND_W-1:0] rnd_mod;

  assign rnd_mod = rnd % RAND_W'(N);

  always_comb begin
    same_hit = 1'b0;
    same_idx = '0;
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!same_hit && same_vec[i]) begin
        same_hit = 1'b1;
        same_idx = IDX_W'(i);
      end
      if (!free_hit && !valid_vec[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (same_hit)      idx = same_idx;
    else if (free_hit) idx = free_idx;
    else               idx = rnd_mod[IDX_W-1:0];
  end
endmodule

// File: rtl/vpn_tlb.sv
`timescale 1ns/1ps
module vpn_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned ASID_W  = DEF_ASID_W,
  parameter int unsigned PFN_W   = DEF_PFN_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned LFSR_W  = 8,
  localparam int unsigned PA_W   = PFN_W + OFF_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [OFF_W-1:0]  lk_off,
  input  logic              lk_write,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic              res_fault,
  output logic [PA_W-1:0]   res_paddr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_rd_ok,
  input  logic              fill_wr_ok,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  logic [LFSR_W-1:0]  lfsr_q;
  logic               q_any;
  logic [PFN_W-1:0]   q_pfn;
  tlb_perm_t          q_perm;
  logic [ENTRIES-1:0] f_match, valid_vec;
  logic [IDX_W-1:0]   vic_idx;
  logic               fill_take, lk_take, allowed;
  tlb_perm_t          new_perm;

  assign fill_ready = !(flush_all || flush_asid_en);
  assign fill_take  = fill_valid && fill_ready;
  assign lk_ready   = !res_valid || res_ready;
  assign lk_take    = lk_valid && lk_ready;
  assign new_perm   = '{rd: fill_rd_ok, wr: fill_wr_ok};

  tlb_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr_q)
  );

  tlb_cam #(
    .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n),
    .q_vpn(lk_vpn), .q_asid(lk_asid),
    .q_any(q_any), .q_pfn(q_pfn), .q_perm(q_perm),
    .f_vpn(fill_vpn), .f_asid(fill_asid),
    .f_match(f_match), .valid_vec(valid_vec),
    .wr_en(fill_take), .wr_idx(vic_idx),
    .wr_pfn(fill_pfn), .wr_perm(new_perm),
    .clr_all(flush_all), .clr_asid_en(flush_asid_en), .clr_asid(flush_asid)
  );

  tlb_victim #(.N(ENTRIES), .RAND_W(LFSR_W)) u_vic (
    .valid_vec(valid_vec), .same_vec(f_match), .rnd(lfsr_q), .idx(vic_idx)
  );

  assign allowed = access_ok(q_perm, lk_write);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
    end else if (lk_take) begin
      res_valid <= 1'b1;
      res_hit   <= q_any && allowed;
      res_fault <= q_any && !allowed;
      res_paddr <= {q_pfn, lk_off};
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vpn_tlb_chk.sv
`timescale 1ns/1ps
module vpn_tlb_chk #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [OFF_W-1:0] lk_off,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_hit,
  input logic             res_fault,
  input logic [PA_W-1:0]  res_paddr,
  input logic             fill_ready,
  input logic             flush_all,
  input logic             flush_asid_en
);
  logic             flush_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      off_q   <= '0;
    end else begin
      flush_q <= flush_all;
      if (lk_valid && lk_ready) off_q <= lk_off;
    end
  end

  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  a_r1_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_paddr[OFF_W-1:0] == off_q));

  a_r4_hit_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_fault));

  a_r8_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !fill_ready);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && lk_valid && lk_ready) |=> (!res_hit && !res_fault));

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_paddr) && $stable(res_hit) && $stable(res_fault)));

  a_r10_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid) |-> lk_ready);
endmodule

bind vpn_tlb vpn_tlb_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_off(lk_off), .res_valid(res_valid), .res_ready(res_ready),
  .res_hit(res_hit), .res_fault(res_fault), .res_paddr(res_paddr),
  .fill_ready(fill_ready), .flush_all(flush_all), .flush_asid_en(flush_asid_en)
);

// File: tb/vpn_tlb_tb.sv
`timescale 1ns/1ps
module vpn_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_write = 0, res_ready = 1;
  logic [19:0] lk_vpn = 0;
  logic [7:0]  lk_asid = 0;
  logic [11:0] lk_off = 0;
  logic        lk_ready, res_valid, res_hit, res_fault, fill_ready;
  logic [31:0] res_paddr;
  logic        fill_valid = 0, fill_rd_ok = 0, fill_wr_ok = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic [7:0]  fill_asid = 0;
  logic        flush_all = 0, flush_asid_en = 0;
  logic [7:0]  flush_asid = 0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vpn_tlb u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a,
                      input logic [19:0] p, input logic r, input logic w);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    fill_rd_ok = r; fill_wr_ok = w;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a,
                      input logic [11:0] o, input logic w,
                      output logic hit, output logic flt, output logic [31:0] pa);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_off = o; lk_write = w;
    @(negedge clk);
    lk_valid = 0;
    hit = res_hit; flt = res_fault; pa = res_paddr;
    chk(res_valid, "R1", "res_valid after accept", 32'(res_valid), 32'd1);
  endtask

  task automatic flush_everything();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  task automatic t_reset();
    logic h, f; logic [31:0] pa;
    chk(!res_valid && lk_ready && fill_ready, "R11", "idle after reset",
        {29'd0, res_valid, lk_ready, fill_ready}, 32'd3);
    look(20'h00000, 8'h0, 12'h0, 0, h, f, pa);
    chk(!h && !f, "R11", "empty after reset", {30'd0, h, f}, 32'd0);
  endtask

  task automatic t_hit_miss();
    logic h, f; logic [31:0] pa;
    flush_everything();
    fill(20'h12345, 8'h07, 20'hABCDE, 1, 1);
    look(20'h12345, 8'h07, 12'h9F3, 0, h, f, pa);
    chk(h && !f, "R1", "hit flag", {30'd0, h, f}, 32'd2);
    chk(pa == 32'hABCDE9F3, "R1", "paddr with offset", pa, 32'hABCDE9F3);
    look(20'h12345, 8'h07, 12'h001, 1, h, f, pa);
    chk(pa == 32'hABCDE001, "R1", "write hit paddr", pa, 32'hABCDE001);
    look(20'h12346, 8'h07, 12'h0, 0, h, f, pa);
    chk(!h && !f, "R2", "miss other page", {30'd0, h, f}, 32'd0);
  endtask

  task automatic t_asid();
    logic h, f; logic [31:0] pa;
    flush_everything();
    fill(20'h00400, 8'h01, 20'h11111, 1, 1);
    fill(20'h00400, 8'h02, 20'h22222, 1, 1);
    look(20'h00400, 8'h01, 12'h0AA, 0, h, f, pa);
    chk(h && pa == 32'h111110AA, "R3", "asid 1 frame", pa, 32'h111110AA);
    look(20'h00400, 8'h02, 12'h0AA, 0, h, f, pa);
    chk(h && pa == 32'h222220AA, "R3", "asid 2 frame", pa, 32'h222220AA);
    look(20'h00400, 8'h03, 12'h0AA, 0, h, f, pa);
    chk(!h && !f, "R2", "unknown asid misses", {30'd0, h, f}, 32'd0);
  endtask

  task automatic t_perm();
    logic h, f; logic [31:0] pa;
    flush_everything();
    fill(20'h00010, 8'h05, 20'h00AAA, 1, 0);
    fill(20'h00020, 8'h05, 20'h00BBB, 0, 1);
    look(20'h00010, 8'h05, 12'h0, 0, h, f, pa);
    chk(h && !f, "R4", "read on read-only", {30'd0, h, f}, 32'd2);
    look(20'h00010, 8'h05, 12'h0, 1, h, f, pa);
    chk(!h && f, "R4", "write on read-only faults", {30'd0, h, f}, 32'd1);
    look(20'h00020, 8'h05, 12'h0, 0, h, f, pa);
    chk(!h && f, "R4", "read on write-only faults", {30'd0, h, f}, 32'd1);
    look(20'h00020, 8'h05, 12'h0, 1, h, f, pa);
    chk(h && !f, "R4", "write on write-only", {30'd0, h, f}, 32'd2);
  endtask

  task automatic fill_sixteen();
    flush_everything();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 8'h09, 20'h00200 + 20'(i), 1, 1);
  endtask

  task automatic t_fill_and_replace();
    logic h, f; logic [31:0] pa;
    int n;
    fill_sixteen();
    n = 0;
    for (int i = 0; i < 16; i++) begin
      look(20'h00100 + 20'(i), 8'h09, 12'h0, 0, h, f, pa);
      if (h && pa[31:12] == 20'h00200 + 20'(i)) n++;
    end
    chk(n == 16, "R5", "all sixteen resident", n, 16);
    fill(20'h00300, 8'h09, 20'h00400, 1, 1);
    look(20'h00300, 8'h09, 12'h0, 0, h, f, pa);
    chk(h && pa[31:12] == 20'h00400, "R6", "new entry resident", pa, 32'h00400000);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      look(20'h00100 + 20'(i), 8'h09, 12'h0, 0, h, f, pa);
      if (h) n++;
    end
    chk(n == 15, "R6", "exactly one evicted", n, 15);
  endtask

  task automatic t_refill();
    logic h, f; logic [31:0] pa;
    int n;
    fill_sixteen();
    fill(20'h00105, 8'h09, 20'h00777, 1, 0);
    look(20'h00105, 8'h09, 12'h0, 0, h, f, pa);
    chk(h && pa[31:12] == 20'h00777, "R7", "rewritten frame", pa, 32'h00777000);
    look(20'h00105, 8'h09, 12'h0, 1, h, f, pa);
    chk(f, "R7", "rewritten permission", {31'd0, f}, 32'd1);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      look(20'h00100 + 20'(i), 8'h09, 12'h0, 0, h, f, pa);
      if (h) n++;
    end
    chk(n == 16, "R7", "no slot lost", n, 16);
  endtask

  task automatic t_flush_all();
    logic h, f; logic [31:0] pa;
    flush_everything();
    fill(20'h00050, 8'h01, 20'h00055, 1, 1);
    @(negedge clk);
    flush_all = 1;
    fill_valid = 1; fill_vpn = 20'h00060; fill_asid = 8'h01; fill_pfn = 20'h00066;
    fill_rd_ok = 1; fill_wr_ok = 1;
    #1 chk(!fill_ready, "R8", "fill_ready low in flush", 32'(fill_ready), 32'd0);
    @(negedge clk);
    flush_all = 0; fill_valid = 0;
    look(20'h00050, 8'h01, 12'h0, 0, h, f, pa);
    chk(!h && !f, "R8", "old entry flushed", {30'd0, h, f}, 32'd0);
    look(20'h00060, 8'h01, 12'h0, 0, h, f, pa);
    chk(!h && !f, "R8", "fill during flush dropped", {30'd0, h, f}, 32'd0);
  endtask

  task automatic t_flush_asid();
    logic h, f; logic [31:0] pa;
    flush_everything();
    fill(20'h00070, 8'h03, 20'h00073, 1, 1);
    fill(20'h00071, 8'h04, 20'h00074, 1, 1);
    fill(20'h00072, 8'h03, 20'h00075, 1, 1);
    @(negedge clk); flush_asid_en = 1; flush_asid = 8'h03;
    @(negedge clk); flush_asid_en = 0;
    look(20'h00070, 8'h03, 12'h0, 0, h, f, pa);
    chk(!h, "R9", "asid 3 entry a cleared", {31'd0, h}, 32'd0);
    look(20'h00072, 8'h03, 12'h0, 0, h, f, pa);
    chk(!h, "R9", "asid 3 entry b cleared", {31'd0, h}, 32'd0);
    look(20'h00071, 8'h04, 12'h0, 0, h, f, pa);
    chk(h && pa[31:12] == 20'h00074, "R9", "asid 4 kept", pa, 32'h00074000);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    flush_everything();
    fill(20'h00080, 8'h02, 20'h00088, 1, 1);
    fill(20'h00081, 8'h02, 20'h00099, 1, 1);
    @(negedge clk);
    res_ready = 0;
    lk_valid = 1; lk_vpn = 20'h00080; lk_asid = 8'h02; lk_off = 12'h123; lk_write = 0;
    @(negedge clk);
    first = res_paddr;
    lk_vpn = 20'h00081; lk_off = 12'h456;
    chk(res_valid && !lk_ready, "R10", "stalled, not ready",
        {30'd0, res_valid, lk_ready}, 32'd2);
    @(negedge clk);
    chk(res_paddr == first && first == 32'h00088123, "R10", "held result stable",
        res_paddr, 32'h00088123);
    res_ready = 1;
    #1 chk(lk_ready, "R10", "ready when taken", 32'(lk_ready), 32'd1);
    @(negedge clk);
    lk_valid = 0;
    chk(res_valid && res_hit && res_paddr == 32'h00099456, "R10", "second result",
        res_paddr, 32'h00099456);
    @(negedge clk);
    chk(!res_valid, "R10", "drained", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hit_miss();
    t_asid();
    t_perm();
    t_fill_and_replace();
    t_refill();
    t_flush_all();
    t_flush_asid();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule